// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers level-sensitive interrupt request lines into one or two banks of 32 sources each. Every request line passes through a two-flop synchronizer before it shows up as raw status. A per-source mask bit gates the status, and the result is the pending vector. All pending bits across all banks are ORed into a single interrupt line for the parent processor.

Software controls the mask through a small word-addressed register bus with a write strobe and a combinational read port. The mask is never written directly. One register sets mask bits and another clears them, so two agents can change different bits without a read-modify-write race. There is no acknowledge register. A source stays pending until its request falls or it is masked.

Each bank also reports a valid flag and the index of its highest-numbered pending source. Service code can then pick a source without scanning the pending word.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1. The raw status, pending and index words read 0, and `irq_out` is 0.
- R2: A request input appears in the raw status word (offset 0x00) after two rising clock edges, and not after only one.
- R3: A write to offset 0x08 sets the mask bit of every source whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to offset 0x0C clears the mask bit of every source whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: Offset 0x04 reads the bank's current mask word, where bit n belongs to source n of the bank.
- R6: Offset 0x10 reads pending, defined as status AND NOT mask. A bit stays set while its request is high and it is unmasked. It drops when the request falls (after the synchronizer delay) or when the bit is masked (after the write edge).
- R7: `irq_out` is 1 exactly when at least one bank has a nonzero pending word.
- R8: Each bank drives a valid flag and the 5-bit index of its most significant pending bit. Offset 0x14 reads the valid flag in bit 31 and the index in bits 4:0, with all other bits 0.
- R9: Bank b occupies addresses b*0x20 to b*0x20+0x1F. Input line b*32+n is source n of bank b, and its index appears in `bank_idx[b*5 +: 5]`.
- R10: Writes to offsets 0x00, 0x04, 0x10 and 0x14 change nothing. Reads of any other offset, and of any bank number at or beyond `NUM_BANKS`, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_BANKS*32 | Level-sensitive request lines, asynchronous |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt to the parent |
| bank_valid | output | NUM_BANKS | Per-bank flag that a source is pending |
| bank_idx | output | NUM_BANKS*5 | Per-bank index of the highest pending source |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` are known and stable around each rising edge. They also assume that one write strobe describes one complete access. The request lines are treated as arbitrary, because the synchronizer absorbs their timing. The stimulus changes every input on the falling edge, holds each write strobe for exactly one cycle, and keeps the requests low during reset so the synchronizer starts clean.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BANKS*32-1:0]   irq_src,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      irq_out,
  output logic [NUM_BANKS-1:0]      bank_valid,
  output logic [NUM_BANKS*5-1:0]    bank_idx
);
  localparam int NSRC  = NUM_BANKS * 32;
  localparam int BSEL_W = ADDR_W - 5;

  localparam logic [4:0] OFF_STAT = 5'h00;
  localparam logic [4:0] OFF_MASK = 5'h04;
  localparam logic [4:0] OFF_SET  = 5'h08;
  localparam logic [4:0] OFF_CLR  = 5'h0C;
  localparam logic [4:0] OFF_PEND = 5'h10;
  localparam logic [4:0] OFF_TOP  = 5'h14;

  logic [NSRC-1:0] sync1_q, stat_q, mask_q, pend;
  logic [31:0]     rd_w [NUM_BANKS];

  wire [4:0]        offs = bus_addr[4:0];
  wire [BSEL_W-1:0] bsel = bus_addr[ADDR_W-1:5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      stat_q  <= '0;
    end else begin
      sync1_q <= irq_src;
      stat_q  <= sync1_q;
    end
  end

  assign pend    = stat_q & ~mask_q;
  assign irq_out = |pend;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic       hit;
    logic [4:0] top;

    assign hit = bus_wr && (bsel == BSEL_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n)
        mask_q[b*32 +: 32] <= '1;
      else if (hit && offs == OFF_SET)
        mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] | bus_wdata;
      else if (hit && offs == OFF_CLR)
        mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] & ~bus_wdata;
    end

    always_comb begin
      top = '0;
      for (int i = 0; i < 32; i++)
        if (pend[b*32 + i]) top = 5'(i);
    end

    assign bank_valid[b]      = |pend[b*32 +: 32];
    assign bank_idx[b*5 +: 5] = top;

    always_comb begin
      case (offs)
        OFF_STAT: rd_w[b] = stat_q[b*32 +: 32];
        OFF_MASK: rd_w[b] = mask_q[b*32 +: 32];
        OFF_PEND: rd_w[b] = pend[b*32 +: 32];
        OFF_TOP:  rd_w[b] = {bank_valid[b], 26'd0, top};
        default:  rd_w[b] = '0;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bsel == BSEL_W'(b)) bus_rdata = rd_w[b];
  end
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_wr,
  input logic [31:0]             bus_wdata,
  input logic                    irq_out,
  input logic [NUM_BANKS-1:0]    bank_valid,
  input logic [NUM_BANKS*5-1:0]  bank_idx,
  input logic [NUM_BANKS*32-1:0] mask_q,
  input logic [NUM_BANKS*32-1:0] pend
);
  wire [4:0] offs = bus_addr[4:0];
  wire       b0   = (bus_addr[ADDR_W-1:5] == '0);

  p_set_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && b0 && offs == 5'h08) |=> ((mask_q[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && b0 && offs == 5'h0C) |=> ((mask_q[31:0] & $past(bus_wdata)) == 32'd0));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || (offs != 5'h08 && offs != 5'h0C)) |=> $stable(mask_q));

  p_irq_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|bank_valid));

  p_idx_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_valid[0] |-> pend[bank_idx[4:0]]);

  p_idx_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_valid[0] |-> (((pend[31:0] >> bank_idx[4:0]) >> 1) == 32'd0));
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .bank_valid(bank_valid),
  .bank_idx(bank_idx), .mask_q(mask_q), .pend(pend)
);

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [1:0]  bank_valid;
  logic [9:0]  bank_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  banked_irq_ctrl #(.NUM_BANKS(2), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .bank_valid(bank_valid), .bank_idx(bank_idx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); chk("R1 mask0", d, 32'hFFFF_FFFF);
    rd(8'h24, d); chk("R1 mask1", d, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R1 stat", d, 0);
    rd(8'h10, d); chk("R1 pend", d, 0);
    rd(8'h14, d); chk("R1 top", d, 0);
    chk("R1 irq_out", {31'd0, irq_out}, 0);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    @(negedge clk); irq_src[3] = 1;
    @(negedge clk);
    rd(8'h00, d); chk("R2 one edge", d, 0);
    @(negedge clk);
    rd(8'h00, d); chk("R2 two edges", d, 32'h8);
  endtask

  task automatic t_mask_ops();
    logic [31:0] d;
    wr(8'h0C, 32'h0000_00FF);
    rd(8'h04, d); chk("R4 clear", d, 32'hFFFF_FF00);
    wr(8'h08, 32'h0000_000F);
    rd(8'h04, d); chk("R3 set", d, 32'hFFFF_FF0F);
    rd(8'h24, d); chk("R5 R9 bank1 mask untouched", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    rd(8'h10, d); chk("R6 masked source", d, 0);
    chk("R7 idle", {31'd0, irq_out}, 0);
    wr(8'h0C, 32'h0000_0008);
    rd(8'h10, d); chk("R6 unmasked", d, 32'h8);
    chk("R7 active", {31'd0, irq_out}, 1);
    rd(8'h14, d); chk("R8 top=3", d, 32'h8000_0003);
    irq_src[7] = 1; settle();
    rd(8'h14, d); chk("R8 top=7", d, 32'h8000_0007);
    chk("R8 port idx", {27'd0, bank_idx[4:0]}, 7);
    @(negedge clk); irq_src[7] = 0; settle();
    rd(8'h14, d); chk("R6 R8 drop", d, 32'h8000_0003);
    wr(8'h08, 32'h0000_0008);
    rd(8'h10, d); chk("R6 masked again", d, 0);
    chk("R7 idle again", {31'd0, irq_out}, 0);
  endtask

  task automatic t_bank1();
    logic [31:0] d;
    wr(8'h2C, 32'h8000_0000);
    @(negedge clk); irq_src[63] = 1; settle();
    rd(8'h30, d); chk("R9 bank1 pend", d, 32'h8000_0000);
    chk("R9 bank1 idx", {27'd0, bank_idx[9:5]}, 31);
    chk("R9 valid", {30'd0, bank_valid}, 2'b10);
    chk("R7 from bank1", {31'd0, irq_out}, 1);
    rd(8'h04, d); chk("R9 bank0 mask", d, 32'hFFFF_FF0F);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(8'h04, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R10 mask unchanged", d, 32'hFFFF_FF0F);
    rd(8'h00, d); chk("R10 stat unchanged", d, 32'h8);
    rd(8'h18, d); chk("R10 unmapped 0x18", d, 0);
    rd(8'h1C, d); chk("R10 unmapped 0x1C", d, 0);
    rd(8'h50, d); chk("R10 absent bank", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sync();
    t_mask_ops();
    t_pending();
    t_bank1();
    t_ignored();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule